// File: doc/BRIEF.md
# Single-Cycle Cipher Processor Core

This core executes one 32-bit instruction per clock from a word-indexed instruction ROM. In that single cycle it decodes the word, reads two operands from a 32-entry register file and computes a result in the ALU. It can also read or write one word of an external data RAM. The register and memory updates take effect at the next rising clock edge.

Besides the usual integer operations, the instruction set has two operations used by block ciphers of the IDEA family. Modular addition works on 16-bit words. Modular multiplication works modulo 2^16+1, with an operand of zero standing for 2^16.

Branches compare two registers and, when the compare succeeds, load the 16-bit immediate into the program counter as an absolute instruction index. A reserved instruction word stops the machine and freezes all of its state until the next reset.

Top module: `cipher_core`

## Requirements
- R1: Synchronous active-high reset sets the instruction address to 0 and clears `halted`.
- R2: Field layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [10:5], immediate [15:0]. The immediate is zero-extended. Opcodes 1 and 9 both write rs + imm into rt, so an immediate of 0xFFFF adds 65535.
- R3: Opcode 0 writes rd. Funct 0 to 5 select add, subtract, multiply, OR, AND and XOR, each keeping the low 32 bits of the result.
- R4: Opcode 11 writes rd with (rs[15:0] + rt[15:0]) mod 65536.
- R5: Opcode 10 writes rd with the product of the two 16-bit operands modulo 65537. An operand of 0 counts as 65536, and a result of 65536 is written as 0.
- R6: Opcode 2 loads rt from data word rs + imm. Opcode 3 stores rt to data word rs + imm. No other instruction asserts the write strobe.
- R7: Opcodes 4 and 5 branch to the absolute index imm when rs equals rt.
- R8: Opcode 6 branches when rt <= rs, and opcode 7 branches when rt >= rs. Both compares are unsigned.
- R9: Every instruction that does not branch advances the instruction address by one.
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: Fetching the word 0x00000001 sets `halted`. From then on the instruction address, the registers and the data memory do not change.
- R12: An undefined opcode writes no register, stores nothing and does not branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction word index (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | DA_W | Data word index |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Store strobe for the current cycle |
| dmem_rdata | input | XLEN | Load data at `dmem_addr` |
| halted | output | 1 | Core has stopped |

## Verification
The bench sweeps operand pairs and targets the following corner cases:
- **Zero operands of the modular multiply.** A core that treated zero as zero instead of 65536 would return 0 for (0,0) rather than 1.
- **16-bit carry out of the modular add.** A core that kept the carry would give 0x10000 for 0xFFFF + 1.
- **Immediate of 0xFFFF.** Sign extension would turn the add into a decrement.
- **Equal, greater and smaller operand pairs for all four branches.** A reversed compare shows up as a skipped or extra increment of a flag register.
- **Write to register 0, an undefined opcode after a result, and a store placed after the halt word.** Each one must leave the stored result or the sentinel word untouched.

// File: rtl/cipher_core_pkg.sv
`timescale 1ns/1ps
package cipher_core_pkg;
    parameter int XLEN      = 32;
    parameter int REG_IDX_W = 5;
    localparam logic [31:0] HALT_WORD = 32'h0000_0001;

    typedef enum logic [5:0] {
        OPC_ALU  = 6'd0,
        OPC_LDI  = 6'd1,
        OPC_LDW  = 6'd2,
        OPC_STW  = 6'd3,
        OPC_BEQ  = 6'd4,
        OPC_BZD  = 6'd5,
        OPC_BNG  = 6'd6,
        OPC_BNL  = 6'd7,
        OPC_ADI  = 6'd9,
        OPC_MMUL = 6'd10,
        OPC_MADD = 6'd11
    } opcode_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_OR, ALU_AND, ALU_XOR,
        ALU_MADD, ALU_MMUL, ALU_LE, ALU_GE
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    use_imm;
        logic    is_branch;
        logic    mem_we;
        logic    mem_to_reg;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] mod_add16(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] s;
        s = a + b;
        return XLEN'(s);
    endfunction

    function automatic logic [XLEN-1:0] mod_mul16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] x, y;
        logic [33:0] p, r;
        x = (a == 16'd0) ? 17'h10000 : {1'b0, a};
        y = (b == 16'd0) ? 17'h10000 : {1'b0, b};
        p = 34'(x) * 34'(y);
        r = p % 34'd65537;
        return (r == 34'd65536) ? '0 : XLEN'(r[16:0]);
    endfunction
endpackage

// File: rtl/cc_alu.sv
`timescale 1ns/1ps
module cc_alu
    import cipher_core_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_MUL:  y = a * b;
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            ALU_XOR:  y = a ^ b;
            ALU_MADD: y = mod_add16(a[15:0], b[15:0]);
            ALU_MMUL: y = mod_mul16(a[15:0], b[15:0]);
            ALU_LE:   y = (b <= a) ? '0 : XLEN'(1);
            ALU_GE:   y = (b >= a) ? '0 : XLEN'(1);
            default:  y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/cc_decode.sv
`timescale 1ns/1ps
module cc_decode
    import cipher_core_pkg::*;
(
    input  logic [31:0]          instr,
    output ctrl_t                ctrl,
    output logic [REG_IDX_W-1:0] rs,
    output logic [REG_IDX_W-1:0] rt,
    output logic [REG_IDX_W-1:0] rd,
    output logic [XLEN-1:0]      imm
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[10:5];
    assign rs  = instr[25:21];
    assign rt  = instr[20:16];
    assign rd  = instr[15:11];
    assign imm = XLEN'(instr[15:0]);

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, is_branch: 1'b0,
                 mem_we: 1'b0, mem_to_reg: 1'b0, alu_op: ALU_ADD};
        case (opc)
            OPC_ALU: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = (fn <= 6'd5);
                case (fn)
                    6'd1:    ctrl.alu_op = ALU_SUB;
                    6'd2:    ctrl.alu_op = ALU_MUL;
                    6'd3:    ctrl.alu_op = ALU_OR;
                    6'd4:    ctrl.alu_op = ALU_AND;
                    6'd5:    ctrl.alu_op = ALU_XOR;
                    default: ctrl.alu_op = ALU_ADD;
                endcase
            end
            OPC_LDI, OPC_ADI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OPC_LDW: begin
                ctrl.reg_we     = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ, OPC_BZD: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            OPC_BNG: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_LE;
            end
            OPC_BNL: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_GE;
            end
            OPC_MADD: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = ALU_MADD;
            end
            OPC_MMUL: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = ALU_MMUL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cc_regfile.sv
`timescale 1ns/1ps
module cc_regfile
    import cipher_core_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]      wdata,
    input  logic [REG_IDX_W-1:0] raddr_a,
    input  logic [REG_IDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]      rdata_a,
    output logic [XLEN-1:0]      rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0)
            regs[waddr] <= wdata;
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/cipher_core.sv
`timescale 1ns/1ps
module cipher_core
    import cipher_core_pkg::*;
#(
    parameter int PC_W = 8,
    parameter int DA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [31:0]     imem_data,
    output logic [DA_W-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            halted
);
    localparam int NREG = 1 << REG_IDX_W;

    logic [PC_W-1:0]      pc_q;
    logic                 halted_q;
    ctrl_t                ctrl;
    logic [REG_IDX_W-1:0] rs, rt, rd, waddr;
    logic [XLEN-1:0]      imm, rs_val, rt_val, alu_b, alu_y, wb_data;
    logic                 alu_zero, halt_now, active, take_br;
    logic [PC_W-1:0]      pc_next;

    cc_decode dec_i (
        .instr(imem_data), .ctrl(ctrl), .rs(rs), .rt(rt), .rd(rd), .imm(imm)
    );

    assign halt_now = (imem_data == HALT_WORD);
    assign active   = !halted_q && !halt_now;
    assign waddr    = ctrl.dst_rd ? rd : rt;
    assign wb_data  = ctrl.mem_to_reg ? dmem_rdata : alu_y;

    cc_regfile #(.NREG(NREG)) rf_i (
        .clk(clk), .we(ctrl.reg_we && active), .waddr(waddr), .wdata(wb_data),
        .raddr_a(rs), .raddr_b(rt), .rdata_a(rs_val), .rdata_b(rt_val)
    );

    assign alu_b = ctrl.use_imm ? imm : rt_val;

    cc_alu alu_i (.op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

    assign take_br = ctrl.is_branch && alu_zero;
    assign pc_next = take_br ? imm[PC_W-1:0] : pc_q + PC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (halt_now) halted_q <= 1'b1;
            else          pc_q     <= pc_next;
        end
    end

    assign imem_addr  = pc_q;
    assign halted     = halted_q;
    assign dmem_addr  = alu_y[DA_W-1:0];
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we && active;
endmodule

// File: rtl/cipher_core_chk.sv
`timescale 1ns/1ps
module cipher_core_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic [31:0]     imem_data,
    input logic            dmem_we,
    input logic            halted
);
    logic [5:0] opc;
    logic       is_br, is_halt;
    assign opc     = imem_data[31:26];
    assign is_br   = (opc >= 6'd4) && (opc <= 6'd7);
    assign is_halt = (imem_data == 32'h0000_0001);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == '0) && !halted);

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && !is_halt && !is_br) |=> imem_addr == $past(imem_addr) + PC_W'(1));

    // R11
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && is_halt) |=> halted && $stable(imem_addr));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(imem_addr));

    // R11
    halt_no_store_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);

    // R6
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opc == 6'd3));
endmodule

bind cipher_core cipher_core_chk #(.PC_W(PC_W)) chk_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_we(dmem_we), .halted(halted)
);

// File: tb/cipher_core_tb_top.sv
`timescale 1ns/1ps
module cipher_core_tb_top;
    localparam int PC_W = 8;
    localparam int DA_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [31:0]     imem_data;
    logic [DA_W-1:0] dmem_addr;
    logic [31:0]     dmem_wdata;
    logic            dmem_we;
    logic [31:0]     dmem_rdata;
    logic            halted;

    logic [31:0] rom [64];
    logic [31:0] ram [16];
    int errors = 0;
    int checks = 0;
    int n = 0;
    int hidx = 0;

    always #2.5 clk = ~clk;

    assign imem_data  = rom[imem_addr[5:0]];
    assign dmem_rdata = ram[dmem_addr[3:0]];
    always @(posedge clk) if (dmem_we) ram[dmem_addr[3:0]] <= dmem_wdata;

    cipher_core #(.PC_W(PC_W), .DA_W(DA_W)) dut_i (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .halted(halted)
    );

    function automatic logic [31:0] enc_r(int op, int rs, int rt, int rd, int fn);
        return {op[5:0], rs[4:0], rt[4:0], rd[4:0], fn[5:0], 5'd0};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic put(input logic [31:0] w);
        rom[n] = w;
        n++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] a, input logic [15:0] b);
        for (int i = 0; i < 64; i++) rom[i] = '0;
        n = 0;
        put(enc_i(1, 0, 1, a));                 // li r1
        put(enc_i(1, 0, 2, b));                 // li r2
        put(enc_i(1, 0, 0, 16'h0055));          // write to r0 (R10)
        for (int f = 0; f < 6; f++) put(enc_r(0, 1, 2, 3 + f, f));
        put(enc_r(11, 1, 2, 9, 0));             // modular add
        put(enc_r(10, 1, 2, 10, 0));            // modular multiply
        put(enc_i(15, 1, 3, 16'h1800));         // undefined opcode aimed at r3 (R12)
        put(enc_i(9, 1, 11, 16'hFFFF));         // add immediate, zero-extended
        for (int k = 0; k < 4; k++) begin
            put(enc_i(1, 0, 13 + k, 0));
            put(enc_i(4 + k, 1, 2, n + 2));
            put(enc_i(9, 13 + k, 13 + k, 1));
        end
        for (int k = 0; k < 9; k++) put(enc_i(3, 0, 3 + k, k));
        put(enc_i(1, 0, 17, 2));                // r17 = 2
        put(enc_i(2, 17, 12, 1));               // r12 = mem[3]
        put(enc_i(3, 17, 12, 7));               // mem[9] = r12
        for (int k = 0; k < 4; k++) put(enc_i(3, 0, 13 + k, 10 + k));
        put(enc_i(3, 0, 0, 14));                // mem[14] = r0
        hidx = n;
        put(32'h0000_0001);
        put(enc_i(3, 0, 3, 15));                // must never execute
    endtask

    task automatic run_pair(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] exp [16];
        longint x, y, p;
        int cyc;
        @(negedge clk);
        rst = 1'b1;
        build(a, b);
        for (int i = 0; i < 16; i++) ram[i] = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc after reset", 32'(imem_addr), 32'd0);
        chk("R1 halted after reset", 32'(halted), 32'd0);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: no halt actual=0 expected=1");
        end
        repeat (3) @(negedge clk);
        x = (a == 0) ? 65536 : longint'(a);
        y = (b == 0) ? 65536 : longint'(b);
        p = (x * y) % 65537;
        if (p == 65536) p = 0;
        exp[0]  = 32'(a) + 32'(b);
        exp[1]  = 32'(a) - 32'(b);
        exp[2]  = 32'(a) * 32'(b);
        exp[3]  = 32'(a | b);
        exp[4]  = 32'(a & b);
        exp[5]  = 32'(a ^ b);
        exp[6]  = (32'(a) + 32'(b)) & 32'hFFFF;
        exp[7]  = 32'(p);
        exp[8]  = 32'(a) + 32'd65535;
        exp[9]  = exp[3];
        exp[10] = (a == b) ? 0 : 1;
        exp[11] = (a == b) ? 0 : 1;
        exp[12] = (b <= a) ? 0 : 1;
        exp[13] = (b >= a) ? 0 : 1;
        exp[14] = 0;
        exp[15] = 32'hDEAD_BEEF;
        chk("R3 R12 add (r3 kept past undefined op)", ram[0], exp[0]);
        chk("R3 sub", ram[1], exp[1]);
        chk("R3 mul", ram[2], exp[2]);
        chk("R3 or", ram[3], exp[3]);
        chk("R3 and", ram[4], exp[4]);
        chk("R3 xor", ram[5], exp[5]);
        chk("R4 modular add", ram[6], exp[6]);
        chk("R5 modular multiply", ram[7], exp[7]);
        chk("R2 add immediate zero-extended", ram[8], exp[8]);
        chk("R6 load/store rs+imm", ram[9], exp[9]);
        chk("R7 op4 branch", ram[10], exp[10]);
        chk("R7 op5 branch", ram[11], exp[11]);
        chk("R8 op6 branch", ram[12], exp[12]);
        chk("R8 op7 branch", ram[13], exp[13]);
        chk("R10 register 0", ram[14], exp[14]);
        chk("R11 no store after halt", ram[15], exp[15]);
        chk("R11 halted", 32'(halted), 32'd1);
        chk("R9 R11 pc held at halt word", 32'(imem_addr), 32'(hidx));
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run_pair(16'h0000, 16'h0000);
        run_pair(16'h0000, 16'h0001);
        run_pair(16'h0005, 16'h0005);
        run_pair(16'hFFFF, 16'hFFFF);
        run_pair(16'h8000, 16'h8000);
        run_pair(16'd1234, 16'd4321);
        run_pair(16'd4321, 16'd1234);
        run_pair(16'hFFFF, 16'h0001);
        run_pair(16'h0000, 16'hFFFF);
        run_pair(16'h0007, 16'h0003);
        for (int i = 0; i < 16; i++)
            run_pair(16'(i * 4099), 16'(i * 7919 + 13));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule